// File: doc/BRIEF.md
# ATM Cell Delineation Engine

This block finds ATM cell boundaries in an unframed, bit-serial payload stream. It slides a five-octet header window over the incoming bits. Each time a test is due, it computes the header error check of the first four octets and compares the result with the fifth octet. A three-state machine (hunting, pre-locked, locked) turns the match results into a lock decision. The upstream framer supplies one payload bit per cycle together with a valid strobe.

The thresholds `delta` and `alpha` are runtime inputs. Typical values are 6 good headers to lock and 7 bad headers to drop lock. The block reports its state in three ways. A `cell_start` pulse marks each header position checked while locked. The `lcd` level signals loss of cell delineation. A small status register holds two sticky event flags, which clear on a read strobe and drive an interrupt line.

Top module: `atm_cell_delin`

## Requirements
- R1: The header check is a CRC-8 with generator x^8+x^2+x+1 and a zero initial value. It runs over the 32 oldest bits of the 40-bit window, earliest-received bit first. The result is XORed with 0x55 and compared with the 8 newest bits.
- R2: Only cycles with `din_vld` high shift a bit in and advance the test schedule. A cycle with `din_vld` low changes neither `lcd` nor `cell_start`.
- R3: After reset the machine is hunting. The first test falls on the 40th valid bit. While hunting, a failed test schedules the next test 425 valid bits later, so the window slips by one bit relative to the cell spacing.
- R4: A passed test while hunting enters the pre-locked state. There, tests fall every 424 valid bits, and a single failed test returns the machine to hunting.
- R5: `delta` consecutive passed tests in the pre-locked state enter the locked state. With no preamble and `delta`=6, lock is declared on valid bit 2584.
- R6: While locked, a failed test increments a miss run and a passed test clears it. When the run reaches `alpha`, the machine returns to hunting. The run counters restart on every state change.
- R7: `lcd` is 1 while hunting or pre-locked and 0 while locked. It changes in the cycle after the deciding bit.
- R8: `cell_start` is a one-cycle pulse in the cycle after every test that leaves the machine locked.
- R9: Status bit 1 is set on every entry to or exit from the locked state. Status bit 0 is set on every failed test in the pre-locked or locked state; failed tests while hunting set nothing. Bits 7 to 2 always read 0.
- R10: A cycle with `stat_rd` high clears the status bits. An event in that same cycle keeps its bit set.
- R11: `irq` is 1 exactly when any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Serial payload bit |
| din_vld | input | 1 | `din` carries a bit this cycle |
| delta | input | CNT_W | Passed tests needed to lock |
| alpha | input | CNT_W | Consecutive failed tests that drop lock |
| stat_rd | input | 1 | Read strobe; clears the status bits |
| cell_start | output | 1 | Pulse after each header test while locked |
| lcd | output | 1 | Loss of cell delineation |
| stat | output | 8 | Status: bit 1 lock change, bit 0 header error |
| irq | output | 1 | OR of the status bits |

## Verification
Every result is registered on the clock edge that samples the bit completing a test window. As a result, `lcd`, `cell_start`, `stat` and `irq` all change exactly one cycle after the deciding valid bit. The bench drives each bit at the falling edge and samples one nanosecond after the next rising edge. At that point it compares all four outputs with a bit-accurate model that it advances in the same step. The lock and unlock positions are also checked against valid-bit counts worked out by hand from the 424-bit cell length and the 425-bit hunt gap. This ties the one-cycle latency to a fixed bit index.

// File: rtl/atm_hec_pkg.sv
package atm_hec_pkg;
  localparam int OCTET_W     = 8;
  localparam int HDR_OCTETS  = 5;
  localparam int CELL_OCTETS = 53;
  localparam int WIN_W       = HDR_OCTETS * OCTET_W;
  localparam int HDR_W       = WIN_W - OCTET_W;
  localparam int CELL_BITS   = CELL_OCTETS * OCTET_W;
  localparam int HUNT_GAP    = CELL_BITS + 1;
  localparam int GAP_W       = $clog2(HUNT_GAP + 1);
  localparam int STAT_W      = 8;
  localparam int N_EV        = 2;

  localparam logic [OCTET_W-1:0] HEC_POLY  = 8'h07;
  localparam logic [OCTET_W-1:0] HEC_COSET = 8'h55;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } dlin_state_e;

  // Serial CRC-8 over the header bits, oldest bit first, then the coset.
  function automatic logic [OCTET_W-1:0] hec_calc(input logic [HDR_W-1:0] hdr);
    logic [OCTET_W-1:0] crc;
    crc = '0;
    for (int i = HDR_W - 1; i >= 0; i--) begin
      crc = {crc[OCTET_W-2:0], 1'b0} ^ ((crc[OCTET_W-1] ^ hdr[i]) ? HEC_POLY : '0);
    end
    return crc ^ HEC_COSET;
  endfunction
endpackage

// File: rtl/hec_window.sv
module hec_window
  import atm_hec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic din_vld,
  output logic hdr_match
);
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_d;

  assign win_d = {win_q[WIN_W-2:0], din};

  always_ff @(posedge clk) begin
    if (!rst_n)       win_q <= '0;
    else if (din_vld) win_q <= win_d;
  end

  // Judged on the window including the bit arriving this cycle.
  assign hdr_match = (hec_calc(win_d[WIN_W-1:OCTET_W]) == win_d[OCTET_W-1:0]);
endmodule

// File: rtl/hec_sync_fsm.sv
module hec_sync_fsm
  import atm_hec_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_vld,
  input  logic             hdr_match,
  input  logic [CNT_W-1:0] delta,
  input  logic [CNT_W-1:0] alpha,
  output logic             test_fire,
  output logic             ev_lcd,
  output logic             ev_hec,
  output logic             in_sync,
  output logic             cell_start
);
  localparam logic [GAP_W-1:0] LIM_HUNT  = GAP_W'(HUNT_GAP - 1);
  localparam logic [GAP_W-1:0] LIM_CELL  = GAP_W'(CELL_BITS - 1);
  localparam logic [GAP_W-1:0] GAP_START = GAP_W'(HUNT_GAP - WIN_W);

  dlin_state_e      state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_lim;
  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W:0]   run_inc;
  logic             cs_q;

  assign gap_lim   = (state_q == ST_HUNT) ? LIM_HUNT : LIM_CELL;
  assign test_fire = din_vld && (gap_q == gap_lim);
  assign run_inc   = {1'b0, run_q} + 1'b1;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    if (test_fire) begin
      unique case (state_q)
        ST_HUNT: if (hdr_match) state_d = ST_PRESYNC;
        ST_PRESYNC: begin
          if (!hdr_match)                      state_d = ST_HUNT;
          else if (run_inc >= {1'b0, delta})   state_d = ST_SYNC;
          else                                 run_d = run_inc[CNT_W-1:0];
        end
        ST_SYNC: begin
          if (hdr_match)                       run_d = '0;
          else if (run_inc >= {1'b0, alpha})   state_d = ST_HUNT;
          else                                 run_d = run_inc[CNT_W-1:0];
        end
        default: state_d = ST_HUNT;
      endcase
    end
    if (state_d != state_q) run_d = '0;
  end

  assign ev_lcd  = test_fire && ((state_q == ST_SYNC) != (state_d == ST_SYNC));
  assign ev_hec  = test_fire && !hdr_match && (state_q != ST_HUNT);
  assign in_sync = (state_q == ST_SYNC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      gap_q   <= GAP_START;
      run_q   <= '0;
      cs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      cs_q    <= test_fire && (state_d == ST_SYNC);
      if (din_vld) gap_q <= test_fire ? '0 : gap_q + 1'b1;
    end
  end

  assign cell_start = cs_q;
endmodule

// File: rtl/hec_status.sv
module hec_status
  import atm_hec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_lcd,
  input  logic              ev_hec,
  input  logic              rd,
  output logic [STAT_W-1:0] stat
);
  logic [N_EV-1:0] ev;
  logic [N_EV-1:0] sticky_q;

  assign ev = {ev_lcd, ev_hec};

  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= ev | (sticky_q & {N_EV{~rd}});
  end

  assign stat = {{(STAT_W-N_EV){1'b0}}, sticky_q};
endmodule

// File: rtl/atm_cell_delin.sv
module atm_cell_delin
  import atm_hec_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              din_vld,
  input  logic [CNT_W-1:0]  delta,
  input  logic [CNT_W-1:0]  alpha,
  input  logic              stat_rd,
  output logic              cell_start,
  output logic              lcd,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic hdr_match;
  logic test_fire;
  logic ev_lcd;
  logic ev_hec;
  logic in_sync;

  hec_window u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .din_vld   (din_vld),
    .hdr_match (hdr_match)
  );

  hec_sync_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .din_vld    (din_vld),
    .hdr_match  (hdr_match),
    .delta      (delta),
    .alpha      (alpha),
    .test_fire  (test_fire),
    .ev_lcd     (ev_lcd),
    .ev_hec     (ev_hec),
    .in_sync    (in_sync),
    .cell_start (cell_start)
  );

  hec_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_lcd (ev_lcd),
    .ev_hec (ev_hec),
    .rd     (stat_rd),
    .stat   (stat)
  );

  assign lcd = ~in_sync;
  assign irq = |stat;
endmodule

// File: rtl/atm_cell_delin_chk.sv
module atm_cell_delin_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       din_vld,
  input logic       stat_rd,
  input logic       lcd,
  input logic       cell_start,
  input logic [7:0] stat,
  input logic       test_fire,
  input logic       hdr_match,
  input logic       ev_lcd,
  input logic       ev_hec
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !din_vld |=> ($stable(lcd) && !cell_start));

  p_lock_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd) |-> $past(test_fire && hdr_match));

  p_drop_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd) |-> $past(test_fire && !hdr_match));

  p_start_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start |-> !lcd);

  p_start_after_test_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start |-> $past(test_fire));

  p_lcd_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd != $past(lcd)) |-> stat[1]);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat[7:2] == 6'd0);

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_rd) && !$past(ev_lcd) && !$past(ev_hec)) |-> (stat[1:0] == 2'b00));
endmodule

bind atm_cell_delin atm_cell_delin_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .din_vld    (din_vld),
  .stat_rd    (stat_rd),
  .lcd        (lcd),
  .cell_start (cell_start),
  .stat       (stat),
  .test_fire  (test_fire),
  .hdr_match  (hdr_match),
  .ev_lcd     (ev_lcd),
  .ev_hec     (ev_hec)
);

// File: tb/test_atm_cell_delin.sv
`timescale 1ns/1ps
module test_atm_cell_delin;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0;
  logic       din_vld = 1'b0;
  logic [3:0] delta = 4'd6;
  logic [3:0] alpha = 4'd7;
  logic       stat_rd = 1'b0;
  logic       cell_start;
  logic       lcd;
  logic [7:0] stat;
  logic       irq;

  always #2 clk = ~clk;

  atm_cell_delin #(.CNT_W(4)) i_atm_cell_delin (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
    .delta(delta), .alpha(alpha), .stat_rd(stat_rd),
    .cell_start(cell_start), .lcd(lcd), .stat(stat), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  logic [39:0] mwin;
  int   nbits, mnext, mst, mrun;
  logic [1:0] estat;
  bit   ecs;
  int   lock_bit, unlock_bit, cs_count;
  bit   prev_lcd;

  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [39:0] v;
    v = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (v[i]) v[i-:9] = v[i-:9] ^ 9'h107;
    return v[7:0] ^ 8'h55;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    mwin = '0; nbits = 0; mnext = 40; mst = 0; mrun = 0;
    estat = 2'b00; ecs = 1'b0;
    lock_bit = -1; unlock_bit = -1; cs_count = 0; prev_lcd = 1'b1;
  endtask

  task automatic do_reset(input int d, input int a);
    @(negedge clk);
    rst_n = 1'b0; din_vld = 1'b0; stat_rd = 1'b0;
    delta = 4'(d); alpha = 4'(a);
    repeat (3) @(negedge clk);
    model_reset();
    check(lcd == 1'b1, "R7 reset lcd", lcd, 1);
    check(cell_start == 1'b0, "R8 reset cell_start", cell_start, 0);
    check(stat == 8'h00, "R9 reset stat", stat, 0);
    check(irq == 1'b0, "R11 reset irq", irq, 0);
    rst_n = 1'b1;
  endtask

  task automatic step(input bit v, input bit b, input bit rd);
    bit el, eh, ok;
    int prv;
    @(negedge clk);
    din = b; din_vld = v; stat_rd = rd;
    el = 0; eh = 0; ecs = 0;
    if (v) begin
      mwin = {mwin[38:0], b};
      nbits++;
      if (nbits == mnext) begin
        ok = (ref_hec(mwin[39:8]) == mwin[7:0]);
        prv = mst;
        case (mst)
          0: if (ok) mst = 1;
          1: begin
            if (!ok) begin mst = 0; eh = 1; end
            else if (mrun + 1 >= int'(delta)) mst = 2;
            else mrun++;
          end
          default: begin
            if (ok) mrun = 0;
            else begin
              eh = 1;
              if (mrun + 1 >= int'(alpha)) mst = 0;
              else mrun++;
            end
          end
        endcase
        if (mst != prv) begin
          mrun = 0;
          if (prv == 2 || mst == 2) el = 1;
        end
        ecs = (mst == 2);
        mnext += (mst == 0) ? 425 : 424;
      end
    end
    estat[1] = el | (estat[1] & ~rd);
    estat[0] = eh | (estat[0] & ~rd);
    @(posedge clk);
    #1;
    check(lcd == (mst != 2), "R7 lcd level", lcd, mst != 2);
    check(cell_start == ecs, "R8 cell_start", cell_start, ecs);
    check(stat == {6'b0, estat}, "R9 R10 status", stat, estat);
    check(irq == (estat != 0), "R11 irq", irq, estat != 0);
    if (!v) check(!cell_start && lcd == prev_lcd, "R2 idle cycle", lcd, prev_lcd);
    if (cell_start) cs_count++;
    if (prev_lcd && !lcd) lock_bit = nbits;
    if (!prev_lcd && lcd) unlock_bit = nbits;
    prev_lcd = lcd;
  endtask

  task automatic send_byte(input logic [7:0] by, input int rdm);
    for (int i = 7; i >= 0; i--) begin
      if ($urandom % 5 == 0) step(1'b0, 1'b0, (rdm != 0) && ($urandom % 3 == 0));
      step(1'b1, by[i], (rdm != 0) && ($urandom % 6 == 0));
    end
  endtask

  task automatic send_cell(input int idx, input bit bad, input int rdm);
    logic [31:0] h;
    h = 32'(idx) << 4;
    for (int k = 3; k >= 0; k--) send_byte(h[k*8 +: 8], rdm);
    send_byte(ref_hec(h) ^ (bad ? 8'h01 : 8'h00), rdm);
    for (int k = 0; k < 48; k++) send_byte(8'h6A ^ 8'(k) ^ 8'(idx), rdm);
  endtask

  initial begin
    model_reset();
    repeat (2) @(negedge clk);

    // S1: clean stream, lock timing
    do_reset(6, 7);
    for (int c = 0; c < 10; c++) send_cell(c, 1'b0, 0);
    check(lock_bit == 2584, "R5 R1 lock bit index", lock_bit, 2584);
    check(cs_count == 4, "R8 cell_start count", cs_count, 4);
    check(stat == 8'h02, "R9 lock change flag", stat, 2);
    check(irq == 1'b1, "R11 irq set", irq, 1);
    step(1'b0, 1'b0, 1'b1);
    check(stat == 8'h00, "R10 read clears", stat, 0);

    // S2: isolated and runs of errors, random reads
    for (int c = 10; c < 31; c++) begin
      bit bad;
      bad = (c == 11) || (c >= 13 && c <= 18) || (c >= 20 && c <= 26);
      send_cell(c, bad, 1);
    end
    check(unlock_bit == 11064, "R6 unlock bit index", unlock_bit, 11064);
    check(lcd == 1'b1, "R7 lcd after unlock", lcd, 1);

    // S3: one-bit preamble, hunt slip
    do_reset(1, 7);
    step(1'b1, 1'b0, 1'b0);
    for (int c = 0; c < 4; c++) send_cell(c, 1'b0, 0);
    check(lock_bit == 889, "R3 slip then lock bit", lock_bit, 889);

    // S4: single miss while pre-locked
    do_reset(4, 7);
    for (int c = 0; c < 3; c++) send_cell(c, c == 2, 0);
    check(lcd == 1'b1, "R4 still unlocked", lcd, 1);
    check(stat == 8'h01, "R4 R9 hec error flagged", stat, 1);
    for (int c = 3; c < 9; c++) send_cell(c, 1'b0, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule